// File: doc/BRIEF.md
# SMBus Host Register Front-End

This block is the software-visible register set of an SMBus host controller. It sits in a 16-byte I/O window. Software loads a target address, a command byte and outgoing data, then starts a transaction by writing a cycle type together with a start bit. A separate protocol engine handles the wire-level bit timing. This block hands the engine a one-cycle start pulse along with stable transaction fields. It then waits for the engine to report that the transaction has finished or has failed.

Each result is caught in a sticky status flag, and software clears a flag by writing a 1 to its bit. Two live indicators sit next to the sticky flags and cannot be cleared by software. One shows that the host is busy. The other, driven from outside the block, shows that the bus is busy. Software can also force an abort, which stops the engine and records the abort as its own flag.

Top module: `smbus_host_regs`

## Requirements
- R1: After reset, reads of status (offset 0x0), control (0x2), target (0x4), data (0x6) and command (0x8) all return 0, and `engStart` and `engAbort` are low.
- R2: A write to the target, data or command register while the host is idle is read back unchanged. The target register is 8 bits: the 7-bit address in bits [7:1] and the direction in bit 0, where 1 means read. The data register is 16 bits and the command register is 8 bits. While the host is busy, writes to these three registers are ignored.
- R3: A control write with bit 3 (start) set, while host busy, bus busy and any pending abort are all clear, gives the following on the next cycle: a one-cycle `engStart` pulse, status bit 3 (host busy) set, and `engCycType` equal to control bits [2:0]. At the same time, `engTarget`, `engCmd` and `engWrData` carry the register values. Control bit 3 always reads 0.
- R4: A start request is ignored while host busy is set or the `busBusy` input (shown in status bit 11) is high. No `engStart` pulse follows and the status word does not change.
- R5: When the engine reports an event while the host is busy, host busy clears on the next cycle and exactly one flag is set. The choice follows a fixed priority: timeout (bit 5) first, then collision (bit 1), then no-acknowledge (bit 2). Completed (bit 4) is set only when none of the three error inputs is high.
- R6: When a transaction with target bit 0 set ends in completion only, `engRdData` is loaded into the data register.
- R7: Engine event inputs have no effect while the host is idle.
- R8: Writing 1s to status bits 0, 1, 2, 4 or 5 clears those flags. Bits 3 and 11 do not change on such a write. A flag set in the same cycle as a clear write stays set.
- R9: A control write with bit 5 set behaves as follows. On the next cycle, control bit 5 reads 1 and `engAbort` is high for one cycle. On the cycle after that, host busy is clear, the aborted flag (status bit 0) is set and control bit 5 reads 0. An abort written together with start wins over the start. Engine events that arrive while the abort is pending are ignored.
- R10: A write to offset 0x9 raises `blkWrStb` in that cycle with `blkWrByte` equal to the low data byte. A read of 0x9 with `rdEn` raises `blkRdStb` and returns `blkRdByte` in the low byte.
- R11: Offsets that are not decoded read as 0. Control bits [2:0] read back the last cycle type written while the host was idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 4 | Byte offset in the register window |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 16 | Write data |
| rdEn | input | 1 | Read strobe (used by the block-data port) |
| rdData | output | 16 | Combinational read data for `regAddr` |
| busBusy | input | 1 | Live bus-busy indication from the line monitor |
| engStart | output | 1 | One-cycle transaction start pulse |
| engAbort | output | 1 | One-cycle abort pulse to the engine |
| engCycType | output | 3 | Selected cycle type |
| engTarget | output | 8 | Target address and direction |
| engCmd | output | 8 | Command byte |
| engWrData | output | 16 | Outgoing data |
| engDone | input | 1 | Engine reports successful end |
| engColl | input | 1 | Engine reports a bus collision |
| engNack | input | 1 | Engine reports no acknowledge |
| engTmo | input | 1 | Engine reports a timeout |
| engRdData | input | 16 | Data returned by a read cycle |
| blkWrStb | output | 1 | Block-data byte written |
| blkWrByte | output | 8 | Byte for the block buffer |
| blkRdStb | output | 1 | Block-data byte consumed |
| blkRdByte | input | 8 | Next byte from the block buffer |

## Verification
A wrong busy state shows at the ports on the very next clock: either an `engStart` pulse appears when it should not, or a legitimate start is refused. A status read then exposes the mismatch in bit 3. If flag priority or clearing is wrong, the status word differs one cycle after an engine event or after a clear write. This happens because every flag is sampled directly after each of these events. If the abort sequencing is wrong, it shows within two cycles in control bit 5, in `engAbort` and in status bits 0 and 3.

// File: rtl/smbus_host_pkg.sv
package smbus_host_pkg;
  localparam logic [3:0] OFF_STAT = 4'h0;
  localparam logic [3:0] OFF_CTRL = 4'h2;
  localparam logic [3:0] OFF_TGT  = 4'h4;
  localparam logic [3:0] OFF_DATA = 4'h6;
  localparam logic [3:0] OFF_CMD  = 4'h8;
  localparam logic [3:0] OFF_BLK  = 4'h9;

  localparam int BIT_START = 3;
  localparam int BIT_ABORT = 5;
  localparam int BIT_HBUSY = 3;
  localparam int BIT_BBUSY = 11;
  localparam int NUM_FLAGS = 5;

  // flag index 0 abort, 1 collision, 2 no-ack, 3 completed, 4 timeout
  function automatic int flagPos(int idx);
    return (idx < 3) ? idx : idx + 1;
  endfunction

  typedef struct packed {
    logic startAccept;
    logic abortFire;
    logic setColl;
    logic setNack;
    logic setDone;
    logic setTmo;
    logic loadRd;
  } hostStrobe_t;
endpackage

// File: rtl/smbus_host_ctrl.sv
module smbus_host_ctrl
  import smbus_host_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        ctrlWr,
  input  logic        startBit,
  input  logic        abortBit,
  input  logic        busBusy,
  input  logic        rdDir,
  input  logic        engDone,
  input  logic        engColl,
  input  logic        engNack,
  input  logic        engTmo,
  output logic        hostBusy,
  output logic        abortPend,
  output hostStrobe_t strb
);
  logic abortReq;
  logic evtTake;
  logic anyErr;

  assign abortReq = ctrlWr && abortBit;
  assign anyErr   = engColl || engNack || engTmo;
  assign evtTake  = hostBusy && !abortPend && (engDone || anyErr);

  always_comb begin
    strb             = '0;
    strb.startAccept = ctrlWr && startBit && !abortReq && !hostBusy
                       && !busBusy && !abortPend;
    strb.abortFire   = abortPend;
    strb.setTmo      = evtTake && engTmo;
    strb.setColl     = evtTake && !engTmo && engColl;
    strb.setNack     = evtTake && !engTmo && !engColl && engNack;
    strb.setDone     = evtTake && !anyErr;
    strb.loadRd      = evtTake && !anyErr && rdDir;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hostBusy  <= 1'b0;
      abortPend <= 1'b0;
    end else begin
      abortPend <= abortReq;
      if (strb.abortFire || evtTake) hostBusy <= 1'b0;
      else if (strb.startAccept)     hostBusy <= 1'b1;
    end
  end
endmodule

// File: rtl/smbus_host_dp.sv
module smbus_host_dp
  import smbus_host_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CYC_W  = 3,
  parameter int BYTE_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [3:0]           regAddr,
  input  logic                 wrEn,
  input  logic [DATA_W-1:0]    wrData,
  input  logic                 busBusy,
  input  logic                 hostBusy,
  input  logic                 abortPend,
  input  hostStrobe_t          strb,
  input  logic [DATA_W-1:0]    engRdData,
  input  logic [BYTE_W-1:0]    blkRdByte,
  output logic [DATA_W-1:0]    rdData,
  output logic                 engStart,
  output logic [CYC_W-1:0]     engCycType,
  output logic [BYTE_W-1:0]    engTarget,
  output logic [BYTE_W-1:0]    engCmd,
  output logic [DATA_W-1:0]    engWrData,
  output logic [NUM_FLAGS-1:0] flagVec
);
  logic [CYC_W-1:0]     cycReg;
  logic [BYTE_W-1:0]    tgtReg;
  logic [BYTE_W-1:0]    cmdReg;
  logic [DATA_W-1:0]    dataReg;
  logic [NUM_FLAGS-1:0] setVec;
  logic                 statWr;

  assign statWr = wrEn && (regAddr == OFF_STAT);
  assign setVec = {strb.setTmo, strb.setDone, strb.setNack, strb.setColl, strb.abortFire};

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rstN) flagVec[g] <= 1'b0;
      else       flagVec[g] <= setVec[g] | (flagVec[g] & ~(statWr & wrData[flagPos(g)]));
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cycReg   <= '0;
      tgtReg   <= '0;
      cmdReg   <= '0;
      dataReg  <= '0;
      engStart <= 1'b0;
    end else begin
      engStart <= strb.startAccept;
      if (wrEn && !hostBusy) begin
        if (regAddr == OFF_CTRL) cycReg <= wrData[CYC_W-1:0];
        if (regAddr == OFF_TGT)  tgtReg <= wrData[BYTE_W-1:0];
        if (regAddr == OFF_CMD)  cmdReg <= wrData[BYTE_W-1:0];
      end
      if (strb.loadRd)                                      dataReg <= engRdData;
      else if (wrEn && !hostBusy && regAddr == OFF_DATA)    dataReg <= wrData;
    end
  end

  always_comb begin
    rdData = '0;
    unique case (regAddr)
      OFF_STAT: begin
        for (int i = 0; i < NUM_FLAGS; i++) rdData[flagPos(i)] = flagVec[i];
        rdData[BIT_HBUSY] = hostBusy;
        rdData[BIT_BBUSY] = busBusy;
      end
      OFF_CTRL: begin
        rdData[CYC_W-1:0] = cycReg;
        rdData[BIT_ABORT] = abortPend;
      end
      OFF_TGT:  rdData[BYTE_W-1:0] = tgtReg;
      OFF_DATA: rdData = dataReg;
      OFF_CMD:  rdData[BYTE_W-1:0] = cmdReg;
      OFF_BLK:  rdData[BYTE_W-1:0] = blkRdByte;
      default:  rdData = '0;
    endcase
  end

  assign engCycType = cycReg;
  assign engTarget  = tgtReg;
  assign engCmd     = cmdReg;
  assign engWrData  = dataReg;
endmodule

// File: rtl/smbus_host_regs.sv
module smbus_host_regs
  import smbus_host_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [3:0]  regAddr,
  input  logic        wrEn,
  input  logic [15:0] wrData,
  input  logic        rdEn,
  output logic [15:0] rdData,
  input  logic        busBusy,
  output logic        engStart,
  output logic        engAbort,
  output logic [2:0]  engCycType,
  output logic [7:0]  engTarget,
  output logic [7:0]  engCmd,
  output logic [15:0] engWrData,
  input  logic        engDone,
  input  logic        engColl,
  input  logic        engNack,
  input  logic        engTmo,
  input  logic [15:0] engRdData,
  output logic        blkWrStb,
  output logic [7:0]  blkWrByte,
  output logic        blkRdStb,
  input  logic [7:0]  blkRdByte
);
  hostStrobe_t          strb;
  logic                 hostBusy;
  logic                 abortPend;
  logic [NUM_FLAGS-1:0] flagVec;

  smbus_host_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .ctrlWr(wrEn && regAddr == OFF_CTRL),
    .startBit(wrData[BIT_START]), .abortBit(wrData[BIT_ABORT]),
    .busBusy(busBusy), .rdDir(engTarget[0]),
    .engDone(engDone), .engColl(engColl), .engNack(engNack), .engTmo(engTmo),
    .hostBusy(hostBusy), .abortPend(abortPend), .strb(strb)
  );

  smbus_host_dp #(.DATA_W(16), .CYC_W(3), .BYTE_W(8)) u_dp (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .wrEn(wrEn), .wrData(wrData),
    .busBusy(busBusy), .hostBusy(hostBusy), .abortPend(abortPend), .strb(strb),
    .engRdData(engRdData), .blkRdByte(blkRdByte), .rdData(rdData),
    .engStart(engStart), .engCycType(engCycType), .engTarget(engTarget),
    .engCmd(engCmd), .engWrData(engWrData), .flagVec(flagVec)
  );

  assign engAbort  = abortPend;
  assign blkWrStb  = wrEn && (regAddr == OFF_BLK);
  assign blkWrByte = wrData[7:0];
  assign blkRdStb  = rdEn && (regAddr == OFF_BLK);
endmodule

// File: rtl/smbus_host_chk.sv
module smbus_host_chk (
  input logic       clk,
  input logic       rstN,
  input logic       hostBusy,
  input logic       busBusy,
  input logic       engStart,
  input logic       engAbort,
  input logic       engEvt,
  input logic [4:0] flagVec
);
  assert_start_sets_busy_R3: assert property (@(posedge clk) disable iff (!rstN)
    engStart |-> hostBusy && $past(!hostBusy));

  assert_start_needs_idle_bus_R4: assert property (@(posedge clk) disable iff (!rstN)
    engStart |-> $past(!busBusy));

  assert_single_flag_R5: assert property (@(posedge clk) disable iff (!rstN)
    $countones(flagVec & ~$past(flagVec)) <= 1);

  assert_busy_drop_cause_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(hostBusy) |-> $past(engAbort) || $past(engEvt));

  assert_abort_outcome_R9: assert property (@(posedge clk) disable iff (!rstN)
    engAbort |=> !hostBusy && flagVec[0] && !engAbort);
endmodule

bind smbus_host_regs smbus_host_chk u_chk (
  .clk(clk), .rstN(rstN), .hostBusy(hostBusy), .busBusy(busBusy),
  .engStart(engStart), .engAbort(engAbort),
  .engEvt(engDone || engColl || engNack || engTmo), .flagVec(flagVec)
);

// File: tb/smbus_host_regs_bench.sv
module smbus_host_regs_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rstN = 0;
  logic [3:0]  regAddr = 0;
  logic        wrEn = 0, rdEn = 0, busBusy = 0;
  logic [15:0] wrData = 0, rdData, engWrData, engRdData = 0;
  logic        engStart, engAbort, engDone = 0, engColl = 0, engNack = 0, engTmo = 0;
  logic [2:0]  engCycType;
  logic [7:0]  engTarget, engCmd, blkWrByte, blkRdByte = 0;
  logic        blkWrStb, blkRdStb;

  int vecs = 0, miss = 0;
  bit finished = 0;
  logic [15:0] mFlags;
  logic [15:0] v;

  always #(CLK_PERIOD/2) clk = ~clk;

  smbus_host_regs u_smbus_host_regs (.*);

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    vecs++;
    if (got !== exp) begin
      miss++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [15:0] d);
    regAddr = a; wrData = d; wrEn = 1;
    @(negedge clk);
    wrEn = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [15:0] val);
    regAddr = a; #1; val = rdData;
  endtask

  function automatic logic [15:0] evtFlag(logic [3:0] e); // e = {tmo,coll,nack,done}
    if (e[3]) return 16'h0020;
    if (e[2]) return 16'h0002;
    if (e[1]) return 16'h0004;
    if (e[0]) return 16'h0010;
    return 16'h0000;
  endfunction

  task automatic pulseEvt(logic [3:0] e);
    {engTmo, engColl, engNack, engDone} = e;
    @(negedge clk);
    {engTmo, engColl, engNack, engDone} = 4'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, miss);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miss++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    mFlags = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R1 reset state
    rd(4'h0, v); chk("R1 status", v, 16'h0000);
    rd(4'h2, v); chk("R1 control", v, 16'h0000);
    rd(4'h4, v); chk("R1 target", v, 16'h0000);
    rd(4'h6, v); chk("R1 data", v, 16'h0000);
    rd(4'h8, v); chk("R1 command", v, 16'h0000);
    chk("R1 engStart/engAbort", {engStart, engAbort}, 2'b00);

    // R2 idle writes read back, R11 unmapped reads zero
    wr(4'h4, 16'hFFA5); rd(4'h4, v); chk("R2 target readback", v, 16'h00A5);
    wr(4'h6, 16'h1234); rd(4'h6, v); chk("R2 data readback", v, 16'h1234);
    wr(4'h8, 16'h775A); rd(4'h8, v); chk("R2 command readback", v, 16'h005A);
    rd(4'hA, v); chk("R11 unmapped 0xA", v, 16'h0000);
    rd(4'hE, v); chk("R11 unmapped 0xE", v, 16'h0000);
    wr(4'h2, 16'h0005); rd(4'h2, v); chk("R11 cycle type readback", v, 16'h0005);

    // R7 events while idle are ignored
    pulseEvt(4'b1111);
    rd(4'h0, v); chk("R7 idle events ignored", v, 16'h0000);

    // R4 bus busy blocks start
    busBusy = 1;
    wr(4'h2, 16'h000A);
    chk("R4 no start with bus busy", engStart, 1'b0);
    rd(4'h0, v); chk("R4 status with bus busy", v, 16'h0800);
    busBusy = 0;

    // R3 start and field hand-off
    wr(4'h2, 16'h000B);
    chk("R3 engStart pulse", engStart, 1'b1);
    chk("R3 fields", {engCycType, engTarget, engCmd, engWrData}, {3'd3, 8'hA5, 8'h5A, 16'h1234});
    rd(4'h0, v); chk("R3 host busy", v, 16'h0008);
    rd(4'h2, v); chk("R3 start reads 0", v, 16'h0003);

    // R4 start while busy ignored; R2 writes locked while busy
    wr(4'h2, 16'h000E);
    chk("R4 no restart while busy", engStart, 1'b0);
    rd(4'h0, v); chk("R4 status unchanged", v, 16'h0008);
    wr(4'h4, 16'h0011); rd(4'h4, v); chk("R2 target locked while busy", v, 16'h00A5);
    wr(4'h6, 16'h9999); rd(4'h6, v); chk("R2 data locked while busy", v, 16'h1234);

    // R5/R6 read completion loads data
    engRdData = 16'hBEEF;
    pulseEvt(4'b0001);
    rd(4'h0, v); chk("R5 completed flag", v, 16'h0010);
    rd(4'h6, v); chk("R6 read data loaded", v, 16'hBEEF);

    // R8 clear with bits 3/11 in mask; set-beats-clear
    busBusy = 1;
    wr(4'h0, 16'hFFFF);
    rd(4'h0, v); chk("R8 clear all, live bits kept", v, 16'h0800);
    busBusy = 0;
    wr(4'h2, 16'h0008);
    chk("R3 second start", engStart, 1'b1);
    regAddr = 4'h0; wrData = 16'h0020; wrEn = 1; {engTmo} = 1;
    @(negedge clk);
    wrEn = 0; engTmo = 0;
    rd(4'h0, v); chk("R8 set wins over clear", v, 16'h0020);
    wr(4'h0, 16'h0020);

    // R9 abort, with a coincident done ignored
    wr(4'h2, 16'h0009);
    chk("R9 start before abort", engStart, 1'b1);
    wr(4'h2, 16'h0020);
    chk("R9 engAbort high", engAbort, 1'b1);
    rd(4'h2, v); chk("R9 abort bit pending", v[5], 1'b1);
    pulseEvt(4'b0001);
    rd(4'h0, v); chk("R9 aborted only, not busy", v, 16'h0001);
    rd(4'h2, v); chk("R9 abort bit cleared", v[5], 1'b0);
    chk("R9 engAbort low", engAbort, 1'b0);
    wr(4'h0, 16'h0001);

    // R9 abort together with start wins
    wr(4'h2, 16'h0028);
    chk("R9 start suppressed by abort", engStart, 1'b0);
    @(negedge clk);
    rd(4'h0, v); chk("R9 abort flag from combined write", v, 16'h0001);
    wr(4'h0, 16'h0001);

    // R10 block-data port
    regAddr = 4'h9; wrData = 16'h33C4; wrEn = 1; #1;
    chk("R10 block write strobe", {blkWrStb, blkWrByte}, {1'b1, 8'hC4});
    @(negedge clk); wrEn = 0;
    blkRdByte = 8'h6E; rdEn = 1; #1;
    chk("R10 block read", {blkRdStb, rdData}, {1'b1, 16'h006E});
    rdEn = 0; #1;
    chk("R10 no strobe without rdEn", blkRdStb, 1'b0);

    // Random transactions: R3 R5 R6 R8
    mFlags = 0;
    for (int i = 0; i < 60; i++) begin
      logic [7:0] tgt; logic [7:0] cmd; logic [2:0] cyc; logic [3:0] e;
      logic [15:0] dIn, rdv, mask;
      tgt = 8'($urandom); cmd = 8'($urandom); cyc = 3'($urandom);
      dIn = 16'($urandom); rdv = 16'($urandom);
      e = 4'($urandom_range(1, 15));
      wr(4'h4, {8'h0, tgt});
      wr(4'h8, {8'h0, cmd});
      wr(4'h6, dIn);
      wr(4'h2, {13'h0, 1'b1, cyc} | 16'h0);
      chk("R3 random start", {engStart, engCycType, engTarget, engCmd, engWrData},
          {1'b1, cyc, tgt, cmd, dIn});
      engRdData = rdv;
      pulseEvt(e);
      mFlags = mFlags | evtFlag(e);
      rd(4'h0, v); chk("R5 random flag", v, mFlags);
      rd(4'h6, v);
      chk("R6 random data", v, (tgt[0] && e == 4'b0001) ? rdv : dIn);
      mask = 16'($urandom);
      wr(4'h0, mask);
      mFlags = mFlags & ~(mask & 16'h0037);
      rd(4'h0, v); chk("R8 random clear", v, mFlags);
    end

    finish_run();
  end
endmodule